// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a parallel data word by a whole number of clock cycles chosen at run time. The path is a cascade of shift-register segments whose lengths are successive powers of two. The longest segment sits at the input and the shortest at the output. A two-way selector after each segment either takes that segment's output or steps around it. Each bit of the select word therefore adds its own binary weight to the total delay.

With the default six select bits the delay runs from 0 to 63 cycles. A clock enable stalls the whole cascade at once, so the delay is counted in enabled cycles. Each segment fills from the selector output just upstream of it, and it keeps shifting whether or not its own selector takes its output. A change of the select word therefore acts in the same cycle and uses whatever the segments already hold.

Top module: `binw_delay_line`

## Requirements
- R1: On enabled cycles with a steady select, the output equals the input from D enabled cycles earlier. D is the value of the select word, and select bit i adds 2^i cycles.
- R2: A select of binary 101010 gives a delay of exactly 42 enabled cycles.
- R3: A select of 0 connects the input to the output combinationally, so the output equals the input in the same cycle.
- R4: The extreme nonzero settings hold: select 1 gives one cycle and select 63 (all six bits set) gives 63 cycles.
- R5: All DATA_W bits of a word travel together. Patterns of all ones, all zeros and mixed bits come out unchanged.
- R6: While the enable is low, no stage changes. With select bit 0 set, the output stays constant. Once the enable returns, the delay continues in enabled cycles as if the stalled cycles had not occurred.
- R7: A synchronous reset clears every stage to zero, whatever the enable. After reset with select 63, the first 63 enabled cycles output zero even though the input is nonzero.
- R8: Every segment shifts on every enabled cycle. Each segment is fed by the selector output of the next longer segment, or by the input for the longest one. After a long run with select 0, switching to select 42 makes the output show, in that same cycle, the input from two enabled cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all stages |
| en | input | 1 | Clock enable; low holds every stage |
| din | input | DATA_W | Data word entering the delay line |
| sel | input | SEL_W | Delay select; bit i includes the 2^i-stage segment |
| dout | output | DATA_W | Delayed data word |

## Verification
A change of the select word can fall in the same cycle as a shift of the cascade. The contents of the segments then decide the output instead of a clean fill. The bench provokes this by streaming data with select 0 so that every segment fills straight from the input. It then changes the select in the same cycle as a fresh input word, and requires the output to equal the word pushed two enabled cycles before, because the 2-stage segment is the shortest one now selected. A stall is also combined with an odd delay. The output must stay constant through the stall and then resume the reference-queue sequence with no lost or repeated words.

// File: rtl/binw_delay_line.sv
module binw_delay_line #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] tap [SEL_W+1];

  assign tap[SEL_W] = din;

  for (genvar i = 0; i < SEL_W; i++) begin : g_seg
    localparam int LEN = 1 << i;
    logic [DATA_W-1:0] sr [LEN];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < LEN; k++) sr[k] <= '0;
      end else if (en) begin
        sr[0] <= tap[i+1];
        for (int k = 1; k < LEN; k++) sr[k] <= sr[k-1];
      end
    end

    assign tap[i] = sel[i] ? sr[LEN-1] : tap[i+1];
  end

  assign dout = tap[0];

endmodule

module binw_delay_line_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [DATA_W-1:0] din,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] dout
);

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  // R3
  a_r3_zero_passthru: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (dout == din));

  // R4
  a_r4_single_stage: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(rst) && $past(en) && $past(sel) == SEL_W'(1) && sel == SEL_W'(1))
      |-> (dout == $past(din)));

  // R6
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(rst) && !$past(en) && $stable(sel) && sel[0])
      |-> $stable(dout));

  // R7
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!sel[0] || dout == '0));

endmodule

bind binw_delay_line binw_delay_line_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .din(din), .sel(sel), .dout(dout)
);

// File: tb/binw_delay_line_tb.sv
module binw_delay_line_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] din = '0;
  logic [5:0] sel = 6'd63;
  logic [7:0] dout;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  logic [7:0] hist [0:1023];

  always #2 clk = ~clk;

  binw_delay_line #(.DATA_W(8), .SEL_W(6)) u_dut (
    .clk(clk), .rst(rst), .en(en), .din(din), .sel(sel), .dout(dout)
  );

  function automatic logic [7:0] expv(int d, bit frozen);
    int idx;
    idx = frozen ? n - d : n - 1 - d;
    if (idx < 0) return 8'h00;
    return hist[idx];
  endfunction

  task automatic chk(string tag, logic [7:0] exp);
    checks++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL %s: dout=%h expected=%h", tag, dout, exp);
    end
  endtask

  task automatic step(logic [7:0] d, logic e, logic [5:0] s);
    @(negedge clk);
    din = d; en = e; sel = s;
    if (e) begin hist[n] = d; n++; end
    #1;
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; din = 8'h00; sel = 6'd63;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; n = 0;
    #1;
    chk("R7 reset state", 8'h00);
  endtask

  task automatic run_delay(logic [5:0] s, int count, string tag);
    for (int c = 0; c < count; c++) begin
      step(8'($urandom), 1'b1, s);
      chk(tag, expv(int'(s), 1'b0));
    end
  endtask

  task automatic t_zero();
    reset_dut();
    run_delay(6'd0, 20, "R3 zero delay");
  endtask

  task automatic t_one();
    reset_dut();
    run_delay(6'd1, 20, "R4 delay 1");
  endtask

  task automatic t_42();
    reset_dut();
    run_delay(6'b101010, 100, "R2 delay 42");
  endtask

  task automatic t_63_width();
    logic [7:0] pat;
    reset_dut();
    for (int c = 0; c < 150; c++) begin
      case (c % 4)
        0: pat = 8'hFF;
        1: pat = 8'h00;
        2: pat = 8'hA5;
        default: pat = 8'h5A;
      endcase
      step(pat, 1'b1, 6'd63);
      chk("R4 R5 delay 63 full width", expv(63, 1'b0));
    end
  endtask

  task automatic t_mixed();
    reset_dut();
    run_delay(6'd5, 40, "R1 delay 5");
    reset_dut();
    run_delay(6'd22, 60, "R1 delay 22");
    reset_dut();
    run_delay(6'd37, 80, "R1 delay 37");
  endtask

  task automatic t_stall();
    reset_dut();
    run_delay(6'd13, 30, "R6 before stall");
    for (int c = 0; c < 6; c++) begin
      step(8'($urandom), 1'b0, 6'd13);
      chk("R6 stalled output", expv(13, 1'b1));
    end
    run_delay(6'd13, 25, "R6 after stall");
  endtask

  task automatic t_reset_clear();
    reset_dut();
    run_delay(6'd63, 80, "R7 prefill");
    reset_dut();
    for (int c = 0; c < 63; c++) begin
      step(8'h80 | 8'($urandom), 1'b1, 6'd63);
      chk("R7 cleared stages", 8'h00);
    end
    run_delay(6'd63, 10, "R7 data after clear");
  endtask

  task automatic t_switch();
    reset_dut();
    run_delay(6'd0, 40, "R8 warm-up sel 0");
    step(8'($urandom), 1'b1, 6'b101010);
    chk("R8 switch to 42 same cycle", expv(2, 1'b0));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    t_zero();
    t_one();
    t_42();
    t_63_width();
    t_mixed();
    t_stall();
    t_reset_clear();
    t_switch();
    summary();
    $finish;
  end
endmodule